// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

The walker turns a virtual address into a real address. It reads translation tables held in memory over a 64-bit read port and can walk up to five table levels. A request carries the virtual address, an access kind (read, write or instruction fetch), an address-space selector, a translation-enable flag and a 64-bit/31-bit addressing flag. The walker picks one of three space-designator words from its inputs, checks the address against the range that the designator's type permits, and then follows origin-plus-offset links from level to level until it reaches a page entry.

Each completed request ends with a one-cycle `done` pulse. The pulse carries either a real address with read/write/execute permissions, or a fault code and an exception word. Only one walk is in flight at a time, and `req_ready` is high only while the walker is idle. Small real addresses are relocated into a prefix area given on an input.

Top module: `xlate_walker`

## Requirements
- R1: With `req_xlate_en` low, `raddr` is the page-aligned (4 KiB) virtual address, `perm` (bits {x,w,r}) is 3'b111, `fault_code` is 0, no table read is issued, and `done` rises in the first cycle after the accepting clock edge.
- R2: With `req_wide` low, address bits 63..31 are cleared before any other use of the address.
- R3: `req_space` 2'b00 selects `cr_primary` with mode bits 1, 2'b01 selects `cr_secondary` with mode bits 2, and 2'b11 selects `cr_home` with mode bits 3. The value 2'b10 behaves as 2'b00. The exception word of a fault is the page-aligned address ORed with the mode bits of the space actually walked.
- R4: In the secondary space an instruction fetch (`req_access` 2'b10) walks the primary designator and returns execute permission only. A data access (read 2'b00, write 2'b01) walks the secondary designator and returns read and write permission only.
- R5: The designator type field is bits [3:2]: 0 segment, 1 third region, 2 second region, 3 first region. Before any read, an address with a bit set at or above bit 31 (type 0), bit 42 (type 1) or bit 53 (type 2) ends with `fault_code` 1 (specification). Type 3 has no limit.
- R6: The walk starts at level type+1, where levels 4..1 take byte offset (va>>50), (va>>39), (va>>28), (va>>17), each ANDed with 0x3ff8. Level 0 takes (va>>9)&0x7f8. Each offset is added to the previous word with bits 11..0 cleared, except at level 0, where bits 10..0 are cleared. A walk therefore issues type+2 reads.
- R7: A designator or region/segment entry with bit 5 set ends with `fault_code` 2 (segment). A fetched entry at levels 3..0 whose type field differs from its level ends with `fault_code` 1.
- R8: A designator or region/segment entry with bit 6 set ends the walk successfully with `raddr` equal to the page-aligned virtual address.
- R9: A page entry with bit 10 set ends with `fault_code` 3 (page). Bit 9 marks the page read-only and clears write permission. A write to a read-only page ends with `fault_code` 4 (protection), and its exception word also has bit 2 set. Otherwise `raddr` is the page entry with bits 11..0 cleared.
- R10: A successful real address below 0x2000 has `prefix` added to it; 0x2000 and above pass unchanged.
- R11: `mem_req` is a one-cycle pulse per table read. The walker waits for `mem_rvalid` and then takes `mem_rdata`. `done` lasts one cycle, and `req_ready` is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_access | input | 2 | 0 read, 1 write, 2 fetch |
| req_space | input | 2 | Address-space selector |
| req_xlate_en | input | 1 | Translation enable |
| req_wide | input | 1 | 64-bit addressing when high |
| cr_primary | input | 64 | Primary space designator |
| cr_secondary | input | 64 | Secondary space designator |
| cr_home | input | 64 | Home space designator |
| prefix | input | 64 | Relocation base for low real pages |
| mem_req | output | 1 | Table read strobe |
| mem_addr | output | 64 | Table read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Result pulse |
| fault_code | output | 3 | 0 none, 1 spec, 2 segment, 3 page, 4 protection |
| exc_word | output | 64 | Exception word on a fault |
| raddr | output | 64 | Real address on success |
| perm | output | 3 | Permissions {x,w,r} on success |

## Verification
Results that need no table read are due one cycle after the accepting edge: disabled translation and range faults. A real-space designator adds one cycle. Each table read costs one check cycle, one issue cycle and the wait for `mem_rvalid`, and the result follows one cycle after the last read data. The bench's memory answers exactly two cycles after each strobe, so a walk of n reads finishes in the 4n+1st cycle. The bench samples at falling edges, counts cycles from the accepting edge, and compares that count and the logged read addresses against these figures.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W       = 64;
    localparam int TYPE_LSB   = 2;
    localparam int INV_BIT    = 5;
    localparam int REAL_BIT   = 6;
    localparam int PG_RO_BIT  = 9;
    localparam int PG_INV_BIT = 10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_ISSUE, ST_WAIT, ST_DONE
    } wstate_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_SPEC = 3'd1,
        FLT_SEG  = 3'd2,
        FLT_PAGE = 3'd3,
        FLT_PROT = 3'd4
    } fault_e;

    typedef struct packed {
        wstate_e          st;
        logic [VA_W-1:0]  va;
        logic [VA_W-1:0]  entry;
        logic [2:0]       step;
        logic             top;
        logic [1:0]       xbits;
        logic [2:0]       pmask;
        logic             is_write;
        logic [VA_W-1:0]  maddr;
        logic [VA_W-1:0]  raddr;
        logic [2:0]       perm;
        fault_e           code;
        logic [VA_W-1:0]  exc;
    } walk_t;
endpackage

// File: rtl/xlate_space_sel.sv
module xlate_space_sel #(
    parameter int W = 64
) (
    input  logic [1:0]   space,
    input  logic [1:0]   access,
    input  logic [W-1:0] cr_pri,
    input  logic [W-1:0] cr_sec,
    input  logic [W-1:0] cr_home,
    output logic [W-1:0] desig,
    output logic [1:0]   xbits,
    output logic [2:0]   pmask
);
    always_comb begin
        desig = cr_pri;
        xbits = 2'd1;
        pmask = 3'b111;
        case (space)
            2'b01: begin
                if (access == 2'b10) begin
                    pmask = 3'b100;          // fetch: primary space, execute only
                end else begin
                    desig = cr_sec;
                    xbits = 2'd2;
                    pmask = 3'b011;          // data: secondary space, no execute
                end
            end
            2'b11: begin
                desig = cr_home;
                xbits = 2'd3;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xlate_range_chk.sv
module xlate_range_chk #(
    parameter int W         = 64,
    parameter int PAGE_BITS = 12
) (
    input  logic [W-1:0] va,
    input  logic [1:0]   tidx,
    output logic         ok
);
    localparam int BASE_LIM = PAGE_BITS + 19;   // first bit beyond a segment-only space
    localparam int STRIDE   = 11;

    logic [3:0] fits;
    logic       unused_lo;
    assign unused_lo = ^va[BASE_LIM-1:0];

    generate
        for (genvar t = 0; t < 4; t++) begin : g_lim
            localparam int LIM = BASE_LIM + STRIDE * t;
            if (LIM >= W) begin : g_open
                assign fits[t] = 1'b1;
            end else begin : g_cut
                assign fits[t] = (va[W-1:LIM] == '0);
            end
        end
    endgenerate

    assign ok = fits[tidx];
endmodule

// File: rtl/xlate_index_gen.sv
module xlate_index_gen #(
    parameter int W         = 64,
    parameter int PAGE_BITS = 12,
    parameter int LEVELS    = 4
) (
    input  logic [W-1:0] va,
    input  logic [2:0]   step,
    output logic [W-1:0] offs
);
    localparam int SEG_SHIFT  = PAGE_BITS - 3;
    localparam int REG_SHIFT0 = PAGE_BITS + 5;
    localparam int STRIDE     = 11;
    localparam logic [W-1:0] SEG_MASK = W'(64'h07f8);
    localparam logic [W-1:0] REG_MASK = W'(64'h3ff8);

    logic [W-1:0] lvl_offs [LEVELS+1];
    logic         unused_lo;
    assign unused_lo = ^va[SEG_SHIFT-1:0];

    assign lvl_offs[0] = (va >> SEG_SHIFT) & SEG_MASK;
    generate
        for (genvar g = 1; g <= LEVELS; g++) begin : g_reg
            assign lvl_offs[g] = (va >> (REG_SHIFT0 + STRIDE * (g - 1))) & REG_MASK;
        end
    endgenerate

    always_comb begin
        offs = '0;
        for (int i = 0; i <= LEVELS; i++) begin
            if (int'(step) == i) offs = lvl_offs[i];
        end
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int          PAGE_BITS = 12,
    parameter logic [63:0] LOW_SPAN  = 64'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_vaddr,
    input  logic [1:0]  req_access,
    input  logic [1:0]  req_space,
    input  logic        req_xlate_en,
    input  logic        req_wide,
    input  logic [63:0] cr_primary,
    input  logic [63:0] cr_secondary,
    input  logic [63:0] cr_home,
    input  logic [63:0] prefix,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [63:0] mem_rdata,
    output logic        done,
    output logic [2:0]  fault_code,
    output logic [63:0] exc_word,
    output logic [63:0] raddr,
    output logic [2:0]  perm
);
    localparam int W = VA_W;
    localparam logic [W-1:0] PAGE_MASK    = ~((W'(1) << PAGE_BITS) - W'(1));
    localparam logic [W-1:0] SEG_ORG_MASK = ~((W'(1) << (PAGE_BITS - 1)) - W'(1));
    localparam logic [W-1:0] NARROW_MASK  = W'(64'h7fff_ffff);

    walk_t q, d;

    logic [W-1:0] va_in, va_pg, sel_desig, offs;
    logic [1:0]   sel_xbits;
    logic [2:0]   sel_pmask;
    logic         range_ok;

    assign va_in = req_wide ? req_vaddr : (req_vaddr & NARROW_MASK);
    assign va_pg = va_in & PAGE_MASK;

    xlate_space_sel #(.W(W)) space_i (
        .space(req_space), .access(req_access),
        .cr_pri(cr_primary), .cr_sec(cr_secondary), .cr_home(cr_home),
        .desig(sel_desig), .xbits(sel_xbits), .pmask(sel_pmask)
    );

    xlate_range_chk #(.W(W), .PAGE_BITS(PAGE_BITS)) range_i (
        .va(va_pg), .tidx(sel_desig[TYPE_LSB +: 2]), .ok(range_ok)
    );

    xlate_index_gen #(.W(W), .PAGE_BITS(PAGE_BITS), .LEVELS(4)) index_i (
        .va(q.va), .step(q.step), .offs(offs)
    );

    function automatic logic [W-1:0] to_abs(input logic [W-1:0] raw, input logic [W-1:0] pfx);
        return (raw < LOW_SPAN) ? raw + pfx : raw;
    endfunction

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va       = va_pg;
                    d.xbits    = sel_xbits;
                    d.pmask    = sel_pmask;
                    d.is_write = (req_access == 2'b01);
                    d.entry    = sel_desig;
                    d.step     = {1'b0, sel_desig[TYPE_LSB +: 2]} + 3'd1;
                    d.top      = 1'b1;
                    d.raddr    = '0;
                    d.perm     = '0;
                    d.exc      = '0;
                    d.code     = FLT_NONE;
                    if (!req_xlate_en) begin
                        d.st    = ST_DONE;
                        d.raddr = to_abs(va_pg, prefix);
                        d.perm  = 3'b111;
                    end else if (!range_ok) begin
                        d.st   = ST_DONE;
                        d.code = FLT_SPEC;
                        d.exc  = va_pg | W'(sel_xbits);
                    end else begin
                        d.st = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (q.entry[INV_BIT]) begin
                    d.st   = ST_DONE;
                    d.code = FLT_SEG;
                    d.exc  = q.va | W'(q.xbits);
                end else if (!q.top && q.step <= 3'd3 &&
                             {1'b0, q.entry[TYPE_LSB +: 2]} != q.step) begin
                    d.st   = ST_DONE;
                    d.code = FLT_SPEC;
                    d.exc  = q.va | W'(q.xbits);
                end else if (q.entry[REAL_BIT]) begin
                    d.st    = ST_DONE;
                    d.raddr = to_abs(q.va, prefix);
                    d.perm  = q.pmask;
                end else begin
                    d.maddr = ((q.step == 3'd0) ? (q.entry & SEG_ORG_MASK)
                                                : (q.entry & PAGE_MASK)) + offs;
                    d.st    = ST_ISSUE;
                end
            end
            ST_ISSUE: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    if (q.step == 3'd0) begin
                        d.st = ST_DONE;
                        if (mem_rdata[PG_INV_BIT]) begin
                            d.code = FLT_PAGE;
                            d.exc  = q.va | W'(q.xbits);
                        end else if (mem_rdata[PG_RO_BIT] && q.is_write) begin
                            d.code = FLT_PROT;
                            d.exc  = q.va | W'({1'b1, q.xbits});
                        end else begin
                            d.raddr = to_abs(mem_rdata & PAGE_MASK, prefix);
                            d.perm  = {1'b1, ~mem_rdata[PG_RO_BIT], 1'b1} & q.pmask;
                        end
                    end else begin
                        d.entry = mem_rdata;
                        d.step  = q.step - 3'd1;
                        d.top   = 1'b0;
                        d.st    = ST_CHECK;
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_req    = (q.st == ST_ISSUE);
    assign mem_addr   = q.maddr;
    assign done       = (q.st == ST_DONE);
    assign fault_code = q.code;
    assign exc_word   = q.exc;
    assign raddr      = q.raddr;
    assign perm       = q.perm;
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_vaddr,
    input logic [1:0]  req_space,
    input logic        req_xlate_en,
    input logic        req_wide,
    input logic [63:0] cr_primary,
    input logic        mem_req,
    input logic        done,
    input logic [2:0]  fault_code,
    input logic [63:0] exc_word,
    input logic [2:0]  perm
);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_one_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (done || mem_req) |-> !req_ready);

    a_r1_off_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_xlate_en)
        |=> (done && fault_code == 3'd0 && perm == 3'b111));

    a_r5_segment_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_xlate_en && req_wide && req_space == 2'b00 &&
         cr_primary[3:2] == 2'b00 && req_vaddr[63:31] != '0)
        |=> (done && fault_code == 3'd1));

    a_r9_prot_word: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code == 3'd4) |-> exc_word[2]);
endmodule

bind xlate_walker xlate_walker_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_space(req_space), .req_xlate_en(req_xlate_en),
    .req_wide(req_wide), .cr_primary(cr_primary), .mem_req(mem_req),
    .done(done), .fault_code(fault_code), .exc_word(exc_word), .perm(perm)
);

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [1:0]  req_space = '0;
    logic        req_xlate_en = 1'b0;
    logic        req_wide = 1'b1;
    logic [63:0] cr_primary = 64'h10000;
    logic [63:0] cr_secondary = 64'h30000;
    logic [63:0] cr_home = 64'h40;
    logic [63:0] prefix = 64'h40000;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [2:0]  fault_code;
    logic [63:0] exc_word;
    logic [63:0] raddr;
    logic [2:0]  perm;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xlate_walker dut_i (.*);

    // table memory: fixed two-cycle response
    logic [63:0] rd_log [16];
    int          rd_n = 0;
    int          mem_wait = 0;
    logic [63:0] mem_hold = '0;

    function automatic logic [63:0] tbl(input logic [63:0] a);
        case (a)
            64'h10008: return 64'h20000;
            64'h20118: return 64'h555000;
            64'h20120: return 64'h666200;
            64'h30008: return 64'h40000;
            64'h40118: return 64'h777000;
            64'h50100: return 64'h60004;
            64'h60008: return 64'h70000;
            64'h70118: return 64'h888000;
            64'h50200: return 64'h61000;
            default:   return 64'h420;
        endcase
    endfunction

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (mem_wait > 0) begin
            mem_wait--;
            if (mem_wait == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = tbl(mem_hold);
            end
        end
        if (rst_n && mem_req) begin
            mem_hold = mem_addr;
            mem_wait = 2;
            rd_log[rd_n & 15] = mem_addr;
            rd_n++;
        end
    end

    logic [2:0]  r_code;
    logic [63:0] r_raddr, r_exc;
    logic [2:0]  r_perm;
    int          r_lat, r_nrd, r_base;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] sp,
                          input logic en, input logic wide);
        @(negedge clk);
        chk("R11 ready before request", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_vaddr = va; req_access = acc; req_space = sp;
        req_xlate_en = en; req_wide = wide;
        r_base = rd_n;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        while (!done && r_lat < 200) begin
            @(negedge clk);
            r_lat++;
        end
        if (!done) begin
            errors++;
            $display("FAIL R11 no done: actual 0 expected 1");
        end
        r_code = fault_code; r_raddr = raddr; r_exc = exc_word; r_perm = perm;
        r_nrd = rd_n - r_base;
        @(negedge clk);
        chk("R11 done one cycle", {63'd0, done}, 64'd0);
    endtask

    function automatic logic [63:0] rd_at(input int k);
        return rd_log[(r_base + k) & 15];
    endfunction

    task automatic t_reset();
        chk("R11 reset done", {63'd0, done}, 64'd0);
        chk("R11 reset mem_req", {63'd0, mem_req}, 64'd0);
        chk("R11 reset ready", {63'd0, req_ready}, 64'd1);
    endtask

    task automatic t_xlate_off();
        do_req(64'hFFFF_FFFF_8123_4567, 2'b00, 2'b00, 1'b0, 1'b0);
        chk("R2 narrow mask raddr", r_raddr, 64'h0123_4000);
        chk("R1 perm", {61'd0, r_perm}, 64'h7);
        chk("R1 code", {61'd0, r_code}, 64'd0);
        chk("R1 no reads", 64'(r_nrd), 64'd0);
        chk("R1 latency", 64'(r_lat), 64'd1);
        do_req(64'h1ABC, 2'b00, 2'b00, 1'b0, 1'b1);
        chk("R10 prefix added", r_raddr, 64'h41000);
        do_req(64'h2000, 2'b00, 2'b00, 1'b0, 1'b1);
        chk("R10 boundary unchanged", r_raddr, 64'h2000);
    endtask

    task automatic t_range();
        cr_primary = 64'h10000;
        do_req(64'h8000_0000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R5 segment limit code", {61'd0, r_code}, 64'd1);
        chk("R5 segment limit word", r_exc, 64'h8000_0001);
        chk("R5 no reads", 64'(r_nrd), 64'd0);
        chk("R5 latency", 64'(r_lat), 64'd1);
        cr_primary = 64'h50004;
        do_req(64'h0000_0400_0000_0000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R5 region3 limit word", r_exc, 64'h0000_0400_0000_0001);
        cr_primary = 64'h10000;
    endtask

    task automatic t_seg_walk();
        do_req(64'h0012_3000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R6 seg walk raddr", r_raddr, 64'h555000);
        chk("R6 seg walk perm", {61'd0, r_perm}, 64'h7);
        chk("R6 seg walk reads", 64'(r_nrd), 64'd2);
        chk("R6 first read addr", rd_at(0), 64'h10008);
        chk("R6 page read addr", rd_at(1), 64'h20118);
        chk("R11 walk latency", 64'(r_lat), 64'd9);
    endtask

    task automatic t_region_walk();
        cr_primary = 64'h50004;
        do_req(64'h0000_0010_0012_3000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R6 region walk raddr", r_raddr, 64'h888000);
        chk("R6 region walk reads", 64'(r_nrd), 64'd3);
        chk("R6 level2 addr", rd_at(0), 64'h50100);
        chk("R6 level1 addr", rd_at(1), 64'h60008);
        chk("R6 level0 addr", rd_at(2), 64'h70118);
        chk("R11 region latency", 64'(r_lat), 64'd13);
        do_req(64'h0000_0020_0012_3000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R7 type mismatch code", {61'd0, r_code}, 64'd1);
        chk("R7 type mismatch word", r_exc, 64'h0000_0020_0012_3001);
        cr_primary = 64'h10000;
    endtask

    task automatic t_faults();
        do_req(64'h0020_0000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R7 segment invalid code", {61'd0, r_code}, 64'd2);
        chk("R7 segment invalid word", r_exc, 64'h20_0001);
        chk("R7 reads", 64'(r_nrd), 64'd1);
        do_req(64'h0012_5000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R9 page invalid code", {61'd0, r_code}, 64'd3);
        chk("R9 page invalid word", r_exc, 64'h12_5001);
    endtask

    task automatic t_protect();
        do_req(64'h0012_4000, 2'b00, 2'b00, 1'b1, 1'b1);
        chk("R9 ro read raddr", r_raddr, 64'h666000);
        chk("R9 ro perm", {61'd0, r_perm}, 64'h5);
        do_req(64'h0012_4000, 2'b01, 2'b00, 1'b1, 1'b1);
        chk("R9 write ro code", {61'd0, r_code}, 64'd4);
        chk("R9 write ro word", r_exc, 64'h12_4005);
    endtask

    task automatic t_secondary();
        do_req(64'h0012_3000, 2'b10, 2'b01, 1'b1, 1'b1);
        chk("R4 fetch via primary raddr", r_raddr, 64'h555000);
        chk("R4 fetch perm", {61'd0, r_perm}, 64'h4);
        chk("R4 fetch first read", rd_at(0), 64'h10008);
        do_req(64'h0012_3000, 2'b00, 2'b01, 1'b1, 1'b1);
        chk("R4 data via secondary raddr", r_raddr, 64'h777000);
        chk("R4 data perm", {61'd0, r_perm}, 64'h3);
        chk("R4 data first read", rd_at(0), 64'h30008);
        do_req(64'h0020_0000, 2'b01, 2'b01, 1'b1, 1'b1);
        chk("R3 secondary mode bits", r_exc, 64'h20_0002);
        do_req(64'h0012_3000, 2'b00, 2'b10, 1'b1, 1'b1);
        chk("R3 reserved as primary", r_raddr, 64'h555000);
        chk("R3 reserved perm", {61'd0, r_perm}, 64'h7);
    endtask

    task automatic t_home();
        do_req(64'h0045_6789, 2'b00, 2'b11, 1'b1, 1'b1);
        chk("R8 real space raddr", r_raddr, 64'h456000);
        chk("R8 real space reads", 64'(r_nrd), 64'd0);
        chk("R8 real space latency", 64'(r_lat), 64'd2);
        do_req(64'h8000_0000, 2'b00, 2'b11, 1'b1, 1'b1);
        chk("R3 home mode bits", r_exc, 64'h8000_0003);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_xlate_off();
        t_range();
        t_seg_walk();
        t_region_walk();
        t_faults();
        t_protect();
        t_secondary();
        t_home();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule